// File: doc/BRIEF.md
# Two-of-Four Sparse Dot-Product Engine

This engine computes integer dot products in which the weight operand has been pruned so that every aligned group of four weights keeps no more than two nonzero entries. Weights reach the engine already compressed: per group it receives only the two kept values plus a 2-bit position for each, which tells where in the group that value sat. The activations still arrive dense, four per group. For each kept weight the engine uses its position to pick the matching activation out of the group. Only those two pairs are multiplied, so each dense group of four costs two multiplies per cycle.

The two products of a group are summed into a signed accumulator. A last-group marker ends a dot product. The engine then shows the finished sum with a one-cycle strobe and restarts from zero for the next one. When a group has fewer than two nonzero weights, the upstream packer pads it with a zero value at an unused position. A group whose two positions are equal is malformed. Such a group is flagged on an error output and adds nothing to the sum.

Top module: `sparse_mac24`

## Requirements
- R1: After reset, and whenever reset is applied mid-sum, sumValid and idxError are 0, sumOut is 0, and the running sum restarts from zero.
- R2: Kept weight k (bits 8k+7:8k of wPair) is multiplied by the activation whose element number equals its position index (bits 2k+1:2k of idxPair). Activation element e occupies bits 8e+7:8e of actGroup.
- R3: Each accepted group (inValid high, distinct indices) adds the sum of its two products to the running sum. Cycles with inValid low leave the running sum unchanged.
- R4: A group accepted with inLast high makes sumValid 1 for the following cycle, with sumOut equal to the running sum including that group. The next group starts a fresh sum from zero, even when it follows immediately.
- R5: A group with inValid high and two equal indices raises idxError for exactly the following cycle and contributes nothing to the sum. With inLast, it still closes the dot product.
- R6: sumOut holds its value in every cycle in which sumValid is 0.
- R7: Weights and activations are two's-complement 8-bit values, and the 32-bit sum is signed. For example, -128 times -128 gives 16384 and -128 times 127 gives -16256.
- R8: A zero-valued padding weight at an unused position contributes nothing, whatever activation sits at that position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | A compressed group is presented this cycle |
| inLast | input | 1 | The presented group ends the dot product |
| wPair | input | 16 | Two kept signed weights, value k in bits 8k+7:8k |
| idxPair | input | 4 | Position index of each kept weight, index k in bits 2k+1:2k |
| actGroup | input | 32 | Four dense signed activations, element e in bits 8e+7:8e |
| sumOut | output | 32 | Completed signed dot product |
| sumValid | output | 1 | One-cycle strobe marking a new sumOut |
| idxError | output | 1 | The previous group carried duplicate indices |

## Verification
All three outputs come from registers. Each is due exactly one cycle after the rising edge that accepts a group. The running sum itself is never seen directly: it shows only when a later last group closes the dot product. The bench therefore drives inputs on the falling edge and samples the outputs on the next falling edge, half a cycle after the accepting edge. Checks on idle gaps, duplicate groups and held results use the same sampling point. Each such check is then followed by a closing group whose published sum exposes what the running sum held.

// File: rtl/sparse_mac_pkg.sv
package sparse_mac_pkg;

  // Strobes handed from the control to the datapath each cycle
  typedef struct packed {
    logic accEn;     // add this group's products into the running sum
    logic publish;   // close the dot product and present the result
    logic flagDup;   // group carried duplicate position indices
  } ctrlStrobes_t;

endpackage

// File: rtl/sparse_mac_ctrl.sv
module sparse_mac_ctrl
  import sparse_mac_pkg::*;
#(
  parameter int GROUP = 4,
  parameter int KEEP  = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          inValid,
  input  logic                          inLast,
  input  logic [KEEP*$clog2(GROUP)-1:0] idxPair,
  output ctrlStrobes_t                  strobes,
  output logic                          idxError
);

  localparam int IDX_W = $clog2(GROUP);

  logic dupIdx;

  always_comb begin
    dupIdx = 1'b0;
    for (int a = 0; a < KEEP; a++) begin
      for (int b = a + 1; b < KEEP; b++) begin
        if (idxPair[a*IDX_W +: IDX_W] == idxPair[b*IDX_W +: IDX_W]) dupIdx = 1'b1;
      end
    end
  end

  always_comb begin
    strobes.accEn   = inValid & ~dupIdx;
    strobes.publish = inValid & inLast;
    strobes.flagDup = inValid & dupIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) idxError <= 1'b0;
    else       idxError <= strobes.flagDup;
  end

endmodule

// File: rtl/sparse_mac_dp.sv
module sparse_mac_dp
  import sparse_mac_pkg::*;
#(
  parameter int W_BITS   = 8,
  parameter int ACC_BITS = 32,
  parameter int GROUP    = 4,
  parameter int KEEP     = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctrlStrobes_t                  strobes,
  input  logic [KEEP*W_BITS-1:0]        wPair,
  input  logic [KEEP*$clog2(GROUP)-1:0] idxPair,
  input  logic [GROUP*W_BITS-1:0]       actGroup,
  output logic [ACC_BITS-1:0]           sumOut,
  output logic                          sumValid,
  output logic [ACC_BITS-1:0]           accQ
);

  localparam int IDX_W  = $clog2(GROUP);
  localparam int PROD_W = 2 * W_BITS;

  logic [ACC_BITS-1:0] laneExt [KEEP];

  // One gather-multiply lane per kept weight
  for (genvar k = 0; k < KEEP; k++) begin : g_lane
    logic [W_BITS-1:0]        selAct;
    logic signed [PROD_W-1:0] prod;

    always_comb begin
      selAct = '0;
      for (int e = 0; e < GROUP; e++) begin
        if (idxPair[k*IDX_W +: IDX_W] == IDX_W'(e)) selAct = actGroup[e*W_BITS +: W_BITS];
      end
    end

    assign prod = $signed(wPair[k*W_BITS +: W_BITS]) * $signed(selAct);
    assign laneExt[k] = {{(ACC_BITS-PROD_W){prod[PROD_W-1]}}, prod};
  end

  logic [ACC_BITS-1:0] groupSum;
  logic [ACC_BITS-1:0] accNext;

  always_comb begin
    groupSum = '0;
    if (strobes.accEn) begin
      for (int k = 0; k < KEEP; k++) groupSum = groupSum + laneExt[k];
    end
    accNext = accQ + groupSum;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accQ     <= '0;
      sumOut   <= '0;
      sumValid <= 1'b0;
    end else begin
      sumValid <= strobes.publish;
      if (strobes.publish) begin
        sumOut <= accNext;
        accQ   <= '0;
      end else begin
        accQ   <= accNext;
      end
    end
  end

endmodule

// File: rtl/sparse_mac24.sv
module sparse_mac24
  import sparse_mac_pkg::*;
#(
  parameter int W_BITS   = 8,
  parameter int ACC_BITS = 32,
  parameter int GROUP    = 4,
  parameter int KEEP     = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          inValid,
  input  logic                          inLast,
  input  logic [KEEP*W_BITS-1:0]        wPair,
  input  logic [KEEP*$clog2(GROUP)-1:0] idxPair,
  input  logic [GROUP*W_BITS-1:0]       actGroup,
  output logic [ACC_BITS-1:0]           sumOut,
  output logic                          sumValid,
  output logic                          idxError
);

  ctrlStrobes_t        strobes;
  logic [ACC_BITS-1:0] accQ;

  sparse_mac_ctrl #(.GROUP(GROUP), .KEEP(KEEP)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inLast   (inLast),
    .idxPair  (idxPair),
    .strobes  (strobes),
    .idxError (idxError)
  );

  sparse_mac_dp #(.W_BITS(W_BITS), .ACC_BITS(ACC_BITS), .GROUP(GROUP), .KEEP(KEEP)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .wPair    (wPair),
    .idxPair  (idxPair),
    .actGroup (actGroup),
    .sumOut   (sumOut),
    .sumValid (sumValid),
    .accQ     (accQ)
  );

endmodule

// File: rtl/sparse_mac_chk.sv
module sparse_mac_chk #(
  parameter int ACC_BITS = 32,
  parameter int GROUP    = 4,
  parameter int KEEP     = 2
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          inValid,
  input logic                          inLast,
  input logic [KEEP*$clog2(GROUP)-1:0] idxPair,
  input logic [ACC_BITS-1:0]           sumOut,
  input logic                          sumValid,
  input logic                          idxError,
  input logic [ACC_BITS-1:0]           accQ
);

  localparam int IDX_W = $clog2(GROUP);

  logic sameIdx;
  always_comb begin
    sameIdx = 1'b0;
    for (int a = 0; a < KEEP; a++)
      for (int b = 0; b < KEEP; b++)
        if (a != b && idxPair[a*IDX_W +: IDX_W] == idxPair[b*IDX_W +: IDX_W]) sameIdx = 1'b1;
  end

  a_r4_strobe_follows_last: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inLast) |=> sumValid);
  a_r4_no_spurious_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !(inValid && inLast) |=> !sumValid);
  a_r4_sum_restarts: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inLast) |=> (accQ == '0));
  a_r5_dup_flagged: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && sameIdx) |=> idxError);
  a_r5_no_false_flag: assert property (@(posedge clk) disable iff (!rstN)
    !(inValid && sameIdx) |=> !idxError);
  a_r5_dup_adds_nothing: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && sameIdx && !inLast) |=> $stable(accQ));
  a_r3_idle_holds_sum: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(accQ));
  a_r6_result_held: assert property (@(posedge clk) disable iff (!rstN)
    !sumValid |-> $stable(sumOut));

endmodule

bind sparse_mac24 sparse_mac_chk #(.ACC_BITS(ACC_BITS), .GROUP(GROUP), .KEEP(KEEP)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inLast   (inLast),
  .idxPair  (idxPair),
  .sumOut   (sumOut),
  .sumValid (sumValid),
  .idxError (idxError),
  .accQ     (accQ)
);

// File: tb/sparse_mac24_bench.sv
module sparse_mac24_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inLast = 1'b0;
  logic [15:0] wPair = '0;
  logic [3:0]  idxPair = '0;
  logic [31:0] actGroup = '0;
  logic [31:0] sumOut;
  logic        sumValid;
  logic        idxError;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  sparse_mac24 u_sparse_mac24 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inLast(inLast),
    .wPair(wPair), .idxPair(idxPair), .actGroup(actGroup),
    .sumOut(sumOut), .sumValid(sumValid), .idxError(idxError)
  );

  typedef struct packed {
    logic        last;
    logic [7:0]  w1;
    logic [7:0]  w0;
    logic [1:0]  i1;
    logic [1:0]  i0;
    logic [31:0] act;
    logic [31:0] expSum;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 8'hFE, 8'h05, 2'd0, 2'd2, 32'h04030201, 32'd0},        // 5*3 + -2*1 = 13
    '{1'b1, 8'h03, 8'h01, 2'd1, 2'd3, 32'h0A141E28, 32'd113},      // +10 +90
    '{1'b1, 8'h80, 8'h80, 2'd3, 2'd1, 32'h807F807F, 32'd32768},    // -128*-128 twice
    '{1'b0, 8'h07, 8'h00, 2'd2, 2'd0, 32'h00000000, 32'd0},
    '{1'b1, 8'h00, 8'h7F, 2'd3, 2'd0, 32'hFFFEFDFC, 32'hFFFFFE04}, // 127*-4, pad at 3
    '{1'b1, 8'h02, 8'h80, 2'd1, 2'd0, 32'h0102037F, 32'hFFFFC086}  // -128*127 + 2*3
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, $signed(act), $signed(exp));
    end
  endtask

  // Present one group, let one edge accept it, sample half a cycle later
  task automatic drive(input bit last, input logic [7:0] w1, input logic [7:0] w0,
                       input logic [1:0] i1, input logic [1:0] i0, input logic [31:0] act);
    inValid  = 1'b1;
    inLast   = last;
    wPair    = {w1, w0};
    idxPair  = {i1, i0};
    actGroup = act;
    @(posedge clk);
    @(negedge clk);
    inValid  = 1'b0;
    inLast   = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int c = 0; c < n; c++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 sumValid", {31'd0, sumValid}, 32'd0);
    chk("R1 idxError", {31'd0, idxError}, 32'd0);
    chk("R1 sumOut", sumOut, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // Table walk: R2 R3 R4 R7 R8
    for (int v = 0; v < NVEC; v++) begin
      drive(VECS[v].last, VECS[v].w1, VECS[v].w0, VECS[v].i1, VECS[v].i0, VECS[v].act);
      chk("R4 strobe", {31'd0, sumValid}, {31'd0, VECS[v].last});
      if (VECS[v].last) chk("R2/R7 sum", sumOut, VECS[v].expSum);
    end

    // R6 result held through idle cycles
    idle(3);
    chk("R6 hold", sumOut, 32'hFFFFC086);
    chk("R6 strobe low", {31'd0, sumValid}, 32'd0);

    // R3 idle gap leaves the partial sum alone
    drive(1'b0, 8'h00, 8'd10, 2'd1, 2'd0, 32'h00000001);
    idle(4);
    chk("R3 no strobe in gap", {31'd0, sumValid}, 32'd0);
    drive(1'b1, 8'h00, 8'd1, 2'd2, 2'd1, 32'h00000500);
    chk("R3 sum across gap", sumOut, 32'd15);

    // R5 duplicate indices: flagged, contributes nothing
    drive(1'b0, 8'd9, 8'd50, 2'd2, 2'd2, 32'h01010101);
    chk("R5 flag", {31'd0, idxError}, 32'd1);
    chk("R5 no strobe", {31'd0, sumValid}, 32'd0);
    drive(1'b1, 8'h00, 8'd7, 2'd3, 2'd0, 32'h09090901);
    chk("R5 flag clears", {31'd0, idxError}, 32'd0);
    chk("R5 dup excluded", sumOut, 32'd7);
    drive(1'b1, 8'd4, 8'd4, 2'd1, 2'd1, 32'h01010101);
    chk("R5 dup last strobe", {31'd0, sumValid}, 32'd1);
    chk("R5 dup last flag", {31'd0, idxError}, 32'd1);
    chk("R5 dup last sum", sumOut, 32'd0);

    // R1 reset mid-sum discards the partial sum
    drive(1'b0, 8'h00, 8'd100, 2'd1, 2'd0, 32'h00000001);
    rstN = 1'b0;
    idle(1);
    chk("R1 reset sumOut", sumOut, 32'd0);
    rstN = 1'b1;
    drive(1'b1, 8'h00, 8'd5, 2'd0, 2'd3, 32'h01000000);
    chk("R1 fresh sum", sumOut, 32'd5);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule